// File: doc/BRIEF.md
# MSI PQ-State Delivery Engine

This block delivers one message-signalled interrupt at a time. The interrupt state is not held in local flops. Each source owns a 64-bit entry in a table in system memory. The entry holds a pending bit (P), a queued bit (Q), a generation tag, a destination server and a priority. A trigger names a local source number.

For each trigger the engine works out where that source's entry lives and checks the source against the table configuration. It then fetches the entry through a read port whose latency is not known in advance. From the entry's P and Q bits and its priority, the engine does one of three things:
- presents the interrupt and marks it pending;
- records it as queued;
- drops it.

Each state update goes back to memory as a single byte write. A presented interrupt leaves on a valid/ready channel. It carries the destination server, the global source number and the priority.

A force input on the trigger makes the engine ignore the stored P and Q bits. This is used to re-deliver interrupts that a presenter has rejected. The interrupt presenter and the memory system lie outside the block.

Top module: `msi_pq_engine`

## Requirements
- R1: While reset is high, and after it, until a trigger is accepted: `req_ready` is 1 and `busy`, `rd_req`, `wr_en`, `irq_valid` and `err` are all 0.
- R2: A trigger accepted while `cfg_tbl_en` is 0 gives exactly one `err` pulse. This happens two rising edges after the accept edge, and there is no read, no write and no interrupt.
- R3: A trigger whose source number is greater than or equal to `cfg_tbl_len` is treated as in R2. A source number of `cfg_tbl_len`-1 is processed normally.
- R4: The entry address is `cfg_tbl_base` + 16 × source when `cfg_wide_ent` is 0, and `cfg_tbl_base` + 128 × source when it is 1. It appears on `rd_addr` together with `rd_req`.
- R5: Byte lane i of `rd_rdata` (bits 8i+7..8i) is the memory byte at entry offset i. The entry is big-endian, so after the swap, bit 63 is the top bit of offset 0. Fields in the swapped word:
  - server: bits 63..48;
  - generation: bits 26..25;
  - P: bit 24;
  - Q: bit 16;
  - priority: bits 7..0;
  - every other bit is ignored.
- R6: With {P,Q} = 00 and a priority other than 0xFF, the engine:
  - writes byte 0x01 | (generation << 1) to entry address + 4;
  - presents `irq_server` = server >> 2, `irq_src` = source + `cfg_src_ofs`, and `irq_prio` = priority.
- R7: With {P,Q} = 00 and priority 0xFF (masked), the engine writes byte 0x01 to entry address + 5 and presents nothing.
- R8: With {P,Q} = 10, the engine writes byte 0x01 to entry address + 5 and presents nothing.
- R9: With {P,Q} = 01 or 11, the engine does not write and does not present.
- R10: When `req_force` is 1 on the trigger, {P,Q} is taken as 00 whatever the entry holds.
- R11: `busy` is high, and `req_ready` low, from the accept edge until the request completes. `irq_valid` holds with stable fields until the edge where `irq_ready` is high.
- R12: `rd_req` is a one-cycle pulse two rising edges after the accept edge. `wr_en` is a one-cycle pulse two rising edges after the edge that samples `rd_rvalid`, and any `irq_valid` rises in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Trigger request |
| req_ready | output | 1 | Engine idle, trigger accepted on this edge |
| req_src | input | SRC_W | Local source number |
| req_force | input | 1 | Treat {P,Q} as 00 |
| cfg_tbl_en | input | 1 | Table enable |
| cfg_tbl_len | input | SRC_W+1 | Number of valid sources |
| cfg_tbl_base | input | ADDR_W | Table base address |
| cfg_wide_ent | input | 1 | 1: 128-byte entry stride, 0: 16-byte stride |
| cfg_src_ofs | input | GSRC_W | Offset added to form the global source |
| rd_req | output | 1 | Entry read request pulse |
| rd_addr | output | ADDR_W | Entry address |
| rd_rvalid | input | 1 | Read data valid |
| rd_rdata | input | 64 | Raw entry, byte lane i = offset i |
| wr_en | output | 1 | Byte write pulse |
| wr_addr | output | ADDR_W | Byte write address |
| wr_data | output | 8 | Byte write value |
| irq_valid | output | 1 | Interrupt presented |
| irq_ready | input | 1 | Presenter accepts |
| irq_server | output | 14 | Destination server |
| irq_src | output | GSRC_W | Global source number |
| irq_prio | output | 8 | Priority |
| busy | output | 1 | Request in progress |
| err | output | 1 | Abandoned-request pulse |

## Verification
The read request and any error pulse fall due exactly two rising edges after the accept edge. The byte write and the rise of `irq_valid` fall due exactly two edges after the edge that samples `rd_rvalid`. `irq_valid` falls on the edge after the one where `irq_ready` is seen.

For every trigger, the bench first chooses the read latency and the ready delay. From those it computes the cycle number of each event, and the span of cycles in which `busy` should be high. It then compares every output against that schedule on every falling edge, so an event that comes early, comes late or is missing is caught. Test cases sweep read latencies from zero to several cycles, ready delays of zero and more, both entry strides, and all four P/Q states, with and without force.

// File: rtl/msi_pq_pkg.sv
package msi_pq_pkg;
  // entry layout after byte swap
  localparam int ENT_W      = 64;
  localparam int ENT_BYTES  = ENT_W / 8;
  localparam int SRVF_W     = 16;
  localparam int SRV_LSB    = 48;
  localparam int SRV_SKIP   = 2;
  localparam int SRV_OUT_W  = SRVF_W - SRV_SKIP;
  localparam int GEN_W      = 2;
  localparam int GEN_LSB    = 25;
  localparam int P_BIT      = 24;
  localparam int Q_BIT      = 16;
  localparam int PRIO_W     = 8;
  localparam int PRIO_LSB   = 0;
  localparam int P_BYTE_OFS = 4;
  localparam int Q_BYTE_OFS = 5;
  localparam int NARROW_SH  = 4;
  localparam int WIDE_SH    = 7;

  typedef enum logic [1:0] {ACT_DROP, ACT_SET_Q, ACT_SET_P} act_e;
  typedef enum logic [2:0] {ST_IDLE, ST_CHECK, ST_WAIT, ST_DECIDE, ST_PRESENT} st_e;
endpackage

// File: rtl/msi_ent_locator.sv
module msi_ent_locator
  import msi_pq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SRC_W  = 11
) (
  input  logic [SRC_W-1:0]  src,
  input  logic              tbl_en,
  input  logic [SRC_W:0]    tbl_len,
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic              wide_ent,
  output logic [ADDR_W-1:0] ent_addr,
  output logic              in_range
);
  logic [ADDR_W-1:0] src_ext;
  logic [ADDR_W-1:0] stride_ofs;

  assign src_ext    = ADDR_W'(src);
  assign stride_ofs = wide_ent ? (src_ext << WIDE_SH) : (src_ext << NARROW_SH);
  assign ent_addr   = tbl_base + stride_ofs;
  assign in_range   = tbl_en && ({1'b0, src} < tbl_len);
endmodule

// File: rtl/msi_ent_decoder.sv
module msi_ent_decoder
  import msi_pq_pkg::*;
(
  input  logic [ENT_W-1:0]     raw,
  input  logic                 force_pq,
  output logic [SRV_OUT_W-1:0] dest_srv,
  output logic [PRIO_W-1:0]    prio,
  output logic [GEN_W-1:0]     gen,
  output act_e                 act
);
  logic [ENT_W-1:0] swapped;
  logic [1:0]       pq;
  logic             unused_bits;

  // big-endian entry: byte lane g holds offset g
  for (genvar g = 0; g < ENT_BYTES; g++) begin : g_swap
    assign swapped[ENT_W-1-8*g -: 8] = raw[8*g +: 8];
  end

  assign dest_srv = swapped[SRV_LSB+SRV_SKIP +: SRV_OUT_W];
  assign prio     = swapped[PRIO_LSB +: PRIO_W];
  assign gen      = swapped[GEN_LSB +: GEN_W];
  assign pq       = force_pq ? 2'b00 : {swapped[P_BIT], swapped[Q_BIT]};

  assign unused_bits = ^{swapped[SRV_LSB +: SRV_SKIP], swapped[SRV_LSB-1:GEN_LSB+GEN_W],
                         swapped[P_BIT-1:Q_BIT+1], swapped[Q_BIT-1:PRIO_LSB+PRIO_W]};

  always_comb begin
    unique case (pq)
      2'b00:   act = (prio == '1) ? ACT_SET_Q : ACT_SET_P;
      2'b10:   act = ACT_SET_Q;
      default: act = ACT_DROP;
    endcase
  end
endmodule

// File: rtl/msi_pq_engine.sv
module msi_pq_engine
  import msi_pq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SRC_W  = 11,
  parameter int GSRC_W = 20
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [SRC_W-1:0]     req_src,
  input  logic                 req_force,
  input  logic                 cfg_tbl_en,
  input  logic [SRC_W:0]       cfg_tbl_len,
  input  logic [ADDR_W-1:0]    cfg_tbl_base,
  input  logic                 cfg_wide_ent,
  input  logic [GSRC_W-1:0]    cfg_src_ofs,
  output logic                 rd_req,
  output logic [ADDR_W-1:0]    rd_addr,
  input  logic                 rd_rvalid,
  input  logic [ENT_W-1:0]     rd_rdata,
  output logic                 wr_en,
  output logic [ADDR_W-1:0]    wr_addr,
  output logic [7:0]           wr_data,
  output logic                 irq_valid,
  input  logic                 irq_ready,
  output logic [SRV_OUT_W-1:0] irq_server,
  output logic [GSRC_W-1:0]    irq_src,
  output logic [PRIO_W-1:0]    irq_prio,
  output logic                 busy,
  output logic                 err
);
  st_e                  state;
  logic [SRC_W-1:0]     src_q;
  logic                 force_q;
  logic [ENT_W-1:0]     raw_q;
  logic [ADDR_W-1:0]    loc_addr;
  logic                 loc_ok;
  logic [SRV_OUT_W-1:0] dec_srv;
  logic [PRIO_W-1:0]    dec_prio;
  logic [GEN_W-1:0]     dec_gen;
  act_e                 dec_act;

  msi_ent_locator #(.ADDR_W(ADDR_W), .SRC_W(SRC_W)) u_loc (
    .src      (src_q),
    .tbl_en   (cfg_tbl_en),
    .tbl_len  (cfg_tbl_len),
    .tbl_base (cfg_tbl_base),
    .wide_ent (cfg_wide_ent),
    .ent_addr (loc_addr),
    .in_range (loc_ok)
  );

  msi_ent_decoder u_dec (
    .raw      (raw_q),
    .force_pq (force_q),
    .dest_srv (dec_srv),
    .prio     (dec_prio),
    .gen      (dec_gen),
    .act      (dec_act)
  );

  assign busy      = (state != ST_IDLE);
  assign req_ready = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      src_q      <= '0;
      force_q    <= 1'b0;
      raw_q      <= '0;
      rd_req     <= 1'b0;
      rd_addr    <= '0;
      wr_en      <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
      irq_valid  <= 1'b0;
      irq_server <= '0;
      irq_src    <= '0;
      irq_prio   <= '0;
      err        <= 1'b0;
    end else begin
      rd_req <= 1'b0;
      wr_en  <= 1'b0;
      err    <= 1'b0;
      unique case (state)
        ST_IDLE: if (req_valid) begin
          src_q   <= req_src;
          force_q <= req_force;
          state   <= ST_CHECK;
        end
        ST_CHECK: if (!loc_ok) begin
          err   <= 1'b1;
          state <= ST_IDLE;
        end else begin
          rd_req  <= 1'b1;
          rd_addr <= loc_addr;
          state   <= ST_WAIT;
        end
        ST_WAIT: if (rd_rvalid) begin
          raw_q <= rd_rdata;
          state <= ST_DECIDE;
        end
        ST_DECIDE: begin
          unique case (dec_act)
            ACT_SET_P: begin
              wr_en      <= 1'b1;
              wr_addr    <= rd_addr + ADDR_W'(P_BYTE_OFS);
              wr_data    <= {{(8-GEN_W-1){1'b0}}, dec_gen, 1'b1};
              irq_valid  <= 1'b1;
              irq_server <= dec_srv;
              irq_src    <= GSRC_W'(src_q) + cfg_src_ofs;
              irq_prio   <= dec_prio;
              state      <= ST_PRESENT;
            end
            ACT_SET_Q: begin
              wr_en   <= 1'b1;
              wr_addr <= rd_addr + ADDR_W'(Q_BYTE_OFS);
              wr_data <= 8'h01;
              state   <= ST_IDLE;
            end
            default: state <= ST_IDLE;
          endcase
        end
        ST_PRESENT: if (irq_ready) begin
          irq_valid <= 1'b0;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/msi_pq_engine_chk.sv
module msi_pq_engine_chk #(
  parameter int GSRC_W = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rd_req,
  input logic              wr_en,
  input logic [7:0]        wr_data,
  input logic              irq_valid,
  input logic              irq_ready,
  input logic [13:0]       irq_server,
  input logic [GSRC_W-1:0] irq_src,
  input logic [7:0]        irq_prio,
  input logic              busy,
  input logic              err
);
  a_r12_rd_single: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !rd_req);
  a_r12_wr_single: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);
  a_r2_err_single: assert property (@(posedge clk) disable iff (rst)
    err |=> !err);
  a_r3_err_no_access: assert property (@(posedge clk) disable iff (rst)
    err |-> (!rd_req && !wr_en && !irq_valid));
  a_r11_irq_hold: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && !irq_ready) |=> (irq_valid && $stable(irq_src) && $stable(irq_server) && $stable(irq_prio)));
  a_r11_accept_busy: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> busy);
  a_r6_p_write_with_irq: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_valid) |-> (wr_en && wr_data[0]));
  a_r7_q_byte_value: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !irq_valid) |-> (wr_data == 8'h01));
  a_r1_idle_no_irq: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !irq_valid);
endmodule

bind msi_pq_engine msi_pq_engine_chk #(.GSRC_W(GSRC_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rd_req     (rd_req),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .irq_valid  (irq_valid),
  .irq_ready  (irq_ready),
  .irq_server (irq_server),
  .irq_src    (irq_src),
  .irq_prio   (irq_prio),
  .busy       (busy),
  .err        (err)
);

// File: tb/msi_pq_engine_tb.sv
module msi_pq_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int SRC_W  = 11;
  localparam int GSRC_W = 20;
  localparam int MEM_N  = 4096;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_force = 1'b0;
  logic [SRC_W-1:0] req_src = '0;
  logic cfg_tbl_en = 1'b1, cfg_wide_ent = 1'b0;
  logic [SRC_W:0] cfg_tbl_len = 12'd12;
  logic [ADDR_W-1:0] cfg_tbl_base = 32'h100;
  logic [GSRC_W-1:0] cfg_src_ofs = 20'h01000;
  logic rd_rvalid = 1'b0;
  logic [63:0] rd_rdata = '0;
  logic irq_ready = 1'b0;
  logic req_ready, rd_req, wr_en, irq_valid, busy, err;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [7:0] wr_data, irq_prio;
  logic [13:0] irq_server;
  logic [GSRC_W-1:0] irq_src;

  msi_pq_engine #(.ADDR_W(ADDR_W), .SRC_W(SRC_W), .GSRC_W(GSRC_W)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_src(req_src), .req_force(req_force), .cfg_tbl_en(cfg_tbl_en),
    .cfg_tbl_len(cfg_tbl_len), .cfg_tbl_base(cfg_tbl_base),
    .cfg_wide_ent(cfg_wide_ent), .cfg_src_ofs(cfg_src_ofs),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_rvalid(rd_rvalid), .rd_rdata(rd_rdata),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .irq_valid(irq_valid), .irq_ready(irq_ready), .irq_server(irq_server),
    .irq_src(irq_src), .irq_prio(irq_prio), .busy(busy), .err(err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0, bad = 0;
  bit chk_on = 1'b0;
  logic [7:0] mem [MEM_N];

  // expected schedule (cycle numbers, -1 = none)
  int e_acc = -1, e_end = -1, e_rd = -1, e_err = -1, e_wr = -1, e_lo = -1, e_hi = -1;
  logic [ADDR_W-1:0] e_rd_addr = '0, e_wr_addr = '0;
  logic [7:0] e_wr_data = '0, e_prio = '0;
  logic [13:0] e_srv = '0;
  logic [GSRC_W-1:0] e_src = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // per-cycle comparison against the schedule
  always @(negedge clk) begin
    bit eb, ei;
    if (chk_on) begin
      eb = (cyc >= e_acc) && (cyc < e_end);
      ei = (cyc >= e_lo) && (cyc <= e_hi);
      check(busy == eb, "R11", "busy", 64'(busy), 64'(eb));
      check(req_ready == !eb, "R11", "req_ready", 64'(req_ready), 64'(!eb));
      check(rd_req == (cyc == e_rd), "R12", "rd_req", 64'(rd_req), 64'(cyc == e_rd));
      if (cyc == e_rd) check(rd_addr == e_rd_addr, "R4", "rd_addr", 64'(rd_addr), 64'(e_rd_addr));
      check(err == (cyc == e_err), "R2 R3", "err", 64'(err), 64'(cyc == e_err));
      check(wr_en == (cyc == e_wr), "R12 R9", "wr_en", 64'(wr_en), 64'(cyc == e_wr));
      if (cyc == e_wr) begin
        check(wr_addr == e_wr_addr, "R6 R7 R8", "wr_addr", 64'(wr_addr), 64'(e_wr_addr));
        check(wr_data == e_wr_data, "R6 R7 R8", "wr_data", 64'(wr_data), 64'(e_wr_data));
      end
      check(irq_valid == ei, "R11", "irq_valid", 64'(irq_valid), 64'(ei));
      if (ei) begin
        check(irq_server == e_srv, "R5", "irq_server", 64'(irq_server), 64'(e_srv));
        check(irq_src == e_src, "R6", "irq_src", 64'(irq_src), 64'(e_src));
        check(irq_prio == e_prio, "R5", "irq_prio", 64'(irq_prio), 64'(e_prio));
      end
    end
  end

  function automatic int ent_at(input int src);
    return int'(cfg_tbl_base) + src * (cfg_wide_ent ? 128 : 16);
  endfunction

  task automatic set_ent(input int src, input logic [15:0] srv, input logic [7:0] prio,
                         input bit p, input bit q, input logic [1:0] gen);
    logic [63:0] e;
    int a;
    a = ent_at(src);
    e = '0;
    e[47:32] = 16'hA5A5;  // ignored bits (R5)
    e[15:8]  = 8'h5A;
    e[63:48] = srv; e[26:25] = gen; e[24] = p; e[16] = q; e[7:0] = prio;
    for (int i = 0; i < 8; i++) mem[a + i] = e[63-8*i -: 8];
  endtask

  task automatic do_req(input int src, input bit frc, input int lat, input int rdy);
    logic [63:0] e;
    int a, acc, rv;
    bit ok;
    logic [1:0] pq;
    @(negedge clk);
    acc = cyc + 1;
    req_valid = 1'b1; req_src = SRC_W'(src); req_force = frc;
    ok = cfg_tbl_en && (src < int'(cfg_tbl_len));
    a  = ent_at(src);
    e_acc = acc; e_rd = -1; e_err = -1; e_wr = -1; e_lo = -1; e_hi = -1;
    if (!ok) begin
      e_err = acc + 1; e_end = acc + 1;
      @(negedge clk);
      req_valid = 1'b0;
    end else begin
      for (int i = 0; i < 8; i++) e[63-8*i -: 8] = mem[a + i];
      rv = acc + 1 + lat;
      e_rd = acc + 1; e_rd_addr = ADDR_W'(a);
      pq = frc ? 2'b00 : {e[24], e[16]};
      if (pq == 2'b00 && e[7:0] != 8'hFF) begin
        e_wr = rv + 2; e_wr_addr = ADDR_W'(a + 4); e_wr_data = {5'b0, e[26:25], 1'b1};
        e_lo = rv + 2; e_hi = rv + 2 + rdy; e_end = rv + 3 + rdy;
        e_srv = e[63:50]; e_src = GSRC_W'(src) + cfg_src_ofs; e_prio = e[7:0];
      end else if (pq == 2'b00 || pq == 2'b10) begin
        e_wr = rv + 2; e_wr_addr = ADDR_W'(a + 5); e_wr_data = 8'h01; e_end = rv + 2;
      end else begin
        e_end = rv + 2;
      end
      @(negedge clk);
      req_valid = 1'b0;
      while (cyc < rv) @(negedge clk);
      rd_rvalid = 1'b1;
      for (int i = 0; i < 8; i++) rd_rdata[8*i +: 8] = mem[a + i];
      if (e_wr >= 0) mem[int'(e_wr_addr)] = e_wr_data;
      @(negedge clk);
      rd_rvalid = 1'b0; rd_rdata = '0;
      if (e_lo >= 0) begin
        while (cyc < e_hi) @(negedge clk);
        irq_ready = 1'b1;
        @(negedge clk);
        irq_ready = 1'b0;
      end
    end
    while (cyc < e_end) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    total++; bad++;
    $display("FAIL R11 watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < MEM_N; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(busy == 1'b0, "R1", "busy", 64'(busy), 0);
    check(req_ready == 1'b1, "R1", "req_ready", 64'(req_ready), 1);
    check(rd_req == 1'b0, "R1", "rd_req", 64'(rd_req), 0);
    check(wr_en == 1'b0, "R1", "wr_en", 64'(wr_en), 0);
    check(irq_valid == 1'b0, "R1", "irq_valid", 64'(irq_valid), 0);
    check(err == 1'b0, "R1", "err", 64'(err), 0);
    rst = 1'b0;
    chk_on = 1'b1;
    @(negedge clk);

    set_ent(0, 16'h1234, 8'h05, 1'b0, 1'b0, 2'd2);
    set_ent(3, 16'h0ABC, 8'hFF, 1'b0, 1'b0, 2'd1);
    set_ent(11, 16'hFFFF, 8'h80, 1'b0, 1'b0, 2'd3);
    do_req(0, 1'b0, 0, 2);   // R6: 00 -> set P and present
    do_req(0, 1'b0, 1, 0);   // R8: 10 -> set Q
    do_req(0, 1'b0, 3, 0);   // R9: 11 -> drop
    do_req(0, 1'b1, 0, 1);   // R10: forced presentation
    do_req(3, 1'b0, 4, 0);   // R7: masked -> set Q
    do_req(3, 1'b0, 0, 0);   // R9: 01 -> drop
    do_req(3, 1'b1, 2, 0);   // R10: forced, masked -> set Q
    cfg_src_ofs = 20'h0ABCD;
    do_req(11, 1'b0, 2, 0);  // R3: last valid source
    do_req(12, 1'b0, 0, 0);  // R3: first out-of-range source
    do_req(1500, 1'b0, 0, 0);// R3: far out of range
    cfg_tbl_en = 1'b0;
    do_req(1, 1'b0, 0, 0);   // R2: disabled table
    cfg_tbl_en = 1'b1;
    cfg_wide_ent = 1'b1; cfg_tbl_base = 32'h200;
    set_ent(5, 16'h8007, 8'h3C, 1'b0, 1'b0, 2'd1);
    set_ent(2, 16'h0040, 8'h10, 1'b1, 1'b0, 2'd0);
    do_req(5, 1'b0, 5, 3);   // R4: 128-byte stride
    do_req(2, 1'b0, 1, 0);   // R8 with wide stride
    do_req(2, 1'b1, 0, 0);   // R10: force over pending+queued
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule